// File: doc/BRIEF.md
# USB Link Status LED Indicator Controller

This block turns the link status of a USB mass-storage bridge into visible indications. It drives two active-low pulse-width-modulated LED outputs and two state-indicator pins. The main LED shows whether a USB connection exists. While the disk is busy it blinks, and the blink rate depends on the link speed. During suspend it breathes, with its brightness ramping linearly down and up. The second LED is a heartbeat that runs whenever the block is out of reset. Two indicator pins show the USB3 link power state. They are released (output enables low) when low-power link states are not in use.

All timing is derived from the system clock. A prescaler divides the clock into brightness steps, so that one PWM period spans 2^DUTY_W steps (about 1 kHz from 40 MHz with 8-bit duty). Blink, fade and heartbeat timing is counted in whole PWM periods. A new brightness level is loaded only at a period boundary, so each PWM period carries a single level. The output is low for the first `level` steps of each period, where `level` runs from 0 (dark) to 2^DUTY_W (fully on, 0% high time).

Top module: `usb_link_led_ctrl`

## Requirements
- R1: While `link_up` is 0 the main LED level is 0 (`led_main_n` high for the whole period), whatever `disk_busy`, `link_susp` and `link_ss` are.
- R2: While connected, not suspended and not busy, the main LED is steady fully on (`led_main_n` low for every cycle of every period).
- R3: While connected, not suspended and busy, the main LED alternates between fully on and dark. Each phase lasts BLINK_HALF_USB2 periods when `link_ss`=0 and BLINK_HALF_SS periods when `link_ss`=1. The defaults, 100 and 50 periods, give 5 Hz and 10 Hz. The first phase is on.
- R4: While connected and `link_susp`=1, the main LED fades, and this takes precedence over activity. The level starts at full, steps down by one to 0 and then back up by one to full, and keeps repeating. Each level is held FADE_HOLD periods.
- R5: The output is active low. The number of low cycles in a period equals level × STEP_DIV, and those cycles form a single run at the start of the period.
- R6: The heartbeat output `led_beat_n` alternates between fully on and dark, with each phase lasting BEAT_HALF periods. It starts in the on phase after reset and does not depend on any link input.
- R7: When `lpm_en`=1, the indicator pins encode `ustate`: code 0 (U0) gives a=0,b=0; code 1 (U1) gives a=1,b=0; code 2 (U2) gives a=0,b=1; code 3 (U3) gives a=1,b=1; codes 4 to 7 give a=0,b=0. Both output enables are 1. The pins follow the input one clock later.
- R8: When `lpm_en`=0, both indicator output enables are 0 and both pin values are 0, one clock later.
- R9: A PWM output's level changes only at a period boundary. A change of the link inputs shows up on the outputs no later than the second period boundary after it.
- R10: In reset, `led_main_n` is 1, `led_beat_n` is 0 and both indicator output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (40 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up | input | 1 | USB connection present |
| link_ss | input | 1 | 1 = SuperSpeed link, 0 = USB2 link |
| disk_busy | input | 1 | Disk transfer in progress |
| link_susp | input | 1 | Link in suspend or U3 |
| ustate | input | 3 | Current link power state code (0..3 = U0..U3) |
| lpm_en | input | 1 | Low-power link states (U1/U2) enabled |
| led_main_n | output | 1 | Main status LED, active-low PWM |
| led_beat_n | output | 1 | Heartbeat LED, active-low PWM |
| ind_a | output | 1 | Power-state indicator pin A value |
| ind_b | output | 1 | Power-state indicator pin B value |
| ind_a_oe | output | 1 | Output enable for pin A |
| ind_b_oe | output | 1 | Output enable for pin B |

## Verification
The main LED is driven through a sequence of input patterns: disconnected, connected idle, busy on USB2, busy on SuperSpeed, suspended while busy, and disconnected with every other input set. The per-period low count is measured for each pattern. These measurements tell steady from dark, the two blink half-periods from each other, the fade staircase from a blink, and the precedence rules apart. The heartbeat run lengths are checked across the whole run, so any coupling to the link inputs would show. The indicator pins are swept over all eight state codes with low-power states both enabled and disabled.

// File: rtl/led_ind_pkg.sv
// Shared types and helpers for the USB link LED indicator controller.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable constructs.
package led_ind_pkg;

    // Display pattern selected for the main LED, in priority order.
    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_STEADY = 2'd1,
        MODE_BLINK  = 2'd2,
        MODE_FADE   = 2'd3
    } main_mode_e;

    // Maps a link power state code to the two indicator pins {b, a}.
    function automatic logic [1:0] ustate_pins(input logic [2:0] code);
        logic [1:0] pins;
        case (code)
            3'd1:    pins = 2'b01;
            3'd2:    pins = 2'b10;
            3'd3:    pins = 2'b11;
            default: pins = 2'b00;
        endcase
        return pins;
    endfunction

endpackage

// File: rtl/led_ind_timebase.sv
// Prescaler and PWM position counter.
// The step counter divides clk by STEP_DIV. Each step advances the PWM
// position, which wraps every 2^DUTY_W steps. period_end pulses for one
// clock on the last clock of each PWM period.
// Assumes: STEP_DIV >= 1 and DUTY_W >= 1.
module led_ind_timebase #(
    parameter int STEP_DIV = 156,
    parameter int DUTY_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DUTY_W-1:0] pwm_pos,
    output logic              period_end
);
    localparam int SW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
    localparam logic [SW-1:0]     STEP_LAST = SW'(STEP_DIV - 1);
    localparam logic [DUTY_W-1:0] POS_LAST  = '1;

    logic [SW-1:0]     step_q;
    logic [DUTY_W-1:0] pos_q;
    logic              step_end;

    assign step_end   = (step_q == STEP_LAST);
    assign period_end = step_end && (pos_q == POS_LAST);
    assign pwm_pos    = pos_q;

    // Prescaler: counts clocks within one brightness step.
    always_ff @(posedge clk) begin
        if (!rst_n)        step_q <= '0;
        else if (step_end) step_q <= '0;
        else               step_q <= step_q + 1'b1;
    end

    // PWM position: advances once per step and wraps at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n)        pos_q <= '0;
        else if (step_end) pos_q <= pos_q + 1'b1;
    end

    AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> (pos_q == '0)); // R9

    AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step_end |=> $stable(pos_q)); // R5

endmodule

// File: rtl/led_ind_main_pattern.sv
// Level generator for the main status LED.
// Selects the pattern by priority (disconnected, then suspend fade, then
// activity blink, then steady on). It runs the blink and fade state
// machines and loads a new brightness level once per PWM period.
// Assumes: period_end is a single-clock pulse; half lengths >= 1.
module led_ind_main_pattern
    import led_ind_pkg::*;
#(
    parameter int DUTY_W          = 8,
    parameter int BLINK_HALF_USB2 = 100,
    parameter int BLINK_HALF_SS   = 50,
    parameter int FADE_HOLD       = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            period_end,
    input  logic            link_up,
    input  logic            link_ss,
    input  logic            disk_busy,
    input  logic            link_susp,
    output logic [DUTY_W:0] level
);
    localparam logic [DUTY_W:0] LVL_FULL = {1'b1, {DUTY_W{1'b0}}};
    localparam logic [DUTY_W:0] LVL_ONE  = (DUTY_W+1)'(1);
    localparam int BLINK_MAX = (BLINK_HALF_USB2 > BLINK_HALF_SS) ? BLINK_HALF_USB2 : BLINK_HALF_SS;
    localparam int BW = $clog2(BLINK_MAX + 1);
    localparam int FW = (FADE_HOLD > 1) ? $clog2(FADE_HOLD) : 1;
    localparam logic [FW-1:0] FADE_LAST = FW'(FADE_HOLD - 1);

    main_mode_e      mode;
    logic [BW-1:0]   half_len;
    logic [BW-1:0]   blink_cnt_q;
    logic            blink_on_q;
    logic [DUTY_W:0] fade_lvl_q;
    logic            fade_up_q;
    logic [FW-1:0]   fade_cnt_q;
    logic [DUTY_W:0] level_d;
    logic [DUTY_W:0] level_q;

    // Pattern priority: disconnection overrides everything, then suspend.
    always_comb begin
        if (!link_up)       mode = MODE_OFF;
        else if (link_susp) mode = MODE_FADE;
        else if (disk_busy) mode = MODE_BLINK;
        else                mode = MODE_STEADY;
    end

    // Blink phase length follows the current link speed.
    assign half_len = link_ss ? BW'(BLINK_HALF_SS) : BW'(BLINK_HALF_USB2);

    // Blink state: counts periods in a phase and toggles at the phase end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blink_cnt_q <= '0;
            blink_on_q  <= 1'b1;
        end else if (period_end) begin
            if (mode != MODE_BLINK) begin
                blink_cnt_q <= '0;
                blink_on_q  <= 1'b1;
            end else if (blink_cnt_q + BW'(1) >= half_len) begin
                blink_cnt_q <= '0;
                blink_on_q  <= !blink_on_q;
            end else begin
                blink_cnt_q <= blink_cnt_q + BW'(1);
            end
        end
    end

    // Fade state: a triangular ramp between 0 and full, one step per hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fade_lvl_q <= LVL_FULL;
            fade_up_q  <= 1'b0;
            fade_cnt_q <= '0;
        end else if (period_end) begin
            if (mode != MODE_FADE) begin
                fade_lvl_q <= LVL_FULL;
                fade_up_q  <= 1'b0;
                fade_cnt_q <= '0;
            end else if (fade_cnt_q == FADE_LAST) begin
                fade_cnt_q <= '0;
                if (!fade_up_q) begin
                    if (fade_lvl_q == LVL_ONE) fade_up_q <= 1'b1;
                    fade_lvl_q <= fade_lvl_q - LVL_ONE;
                end else begin
                    if (fade_lvl_q == LVL_FULL - LVL_ONE) fade_up_q <= 1'b0;
                    fade_lvl_q <= fade_lvl_q + LVL_ONE;
                end
            end else begin
                fade_cnt_q <= fade_cnt_q + FW'(1);
            end
        end
    end

    // Level that the selected pattern asks for in the next period.
    always_comb begin
        case (mode)
            MODE_OFF:    level_d = '0;
            MODE_STEADY: level_d = LVL_FULL;
            MODE_BLINK:  level_d = blink_on_q ? LVL_FULL : '0;
            default:     level_d = fade_lvl_q;
        endcase
    end

    // Level register: loaded only at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)          level_q <= '0;
        else if (period_end) level_q <= level_d;
    end

    assign level = level_q;

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> $stable(level_q)); // R9

    AST_DARK_OFFLINE: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && !link_up) |=> (level_q == '0)); // R1

    AST_FADE_SLEW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fade_lvl_q) |-> ((fade_lvl_q == LVL_FULL) ||
                                  (fade_lvl_q + LVL_ONE == $past(fade_lvl_q)) ||
                                  (fade_lvl_q == $past(fade_lvl_q) + LVL_ONE))); // R4

    AST_FADE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fade_lvl_q <= LVL_FULL); // R4

endmodule

// File: rtl/led_ind_beat.sv
// Heartbeat level generator.
// Alternates the level between full and dark, each phase lasting
// BEAT_HALF PWM periods. It starts in the on phase after reset.
// Assumes: period_end is a single-clock pulse; BEAT_HALF >= 1.
module led_ind_beat #(
    parameter int DUTY_W    = 8,
    parameter int BEAT_HALF = 500
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            period_end,
    output logic [DUTY_W:0] level
);
    localparam logic [DUTY_W:0] LVL_FULL = {1'b1, {DUTY_W{1'b0}}};
    localparam int HW = (BEAT_HALF > 1) ? $clog2(BEAT_HALF) : 1;
    localparam logic [HW-1:0] HALF_LAST = HW'(BEAT_HALF - 1);

    logic [HW-1:0]   cnt_q;
    logic            on_q;
    logic [DUTY_W:0] level_q;

    // Phase counter: toggles the beat phase every BEAT_HALF periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            on_q  <= 1'b1;
        end else if (period_end) begin
            if (cnt_q == HALF_LAST) begin
                cnt_q <= '0;
                on_q  <= !on_q;
            end else begin
                cnt_q <= cnt_q + HW'(1);
            end
        end
    end

    // Level register: full or dark, loaded at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)          level_q <= LVL_FULL;
        else if (period_end) level_q <= on_q ? LVL_FULL : '0;
    end

    assign level = level_q;

    AST_BEAT_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q == '0) || (level_q == LVL_FULL)); // R6

    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> $stable(level_q)); // R9

endmodule

// File: rtl/led_ind_pwm_out.sv
// Active-low PWM comparator.
// Drives the output low while the PWM position is below the level. Level 0
// keeps the LED dark, and level 2^DUTY_W keeps it fully on (0% high time).
// Assumes: level and pwm_pos come from registers, so the output is free
// of glitches apart from comparator settling.
module led_ind_pwm_out #(
    parameter int DUTY_W = 8
) (
    input  logic [DUTY_W-1:0] pwm_pos,
    input  logic [DUTY_W:0]   level,
    output logic              led_n
);
    // Comparator: low (lit) for the first `level` steps of the period.
    always_comb begin
        led_n = !({1'b0, pwm_pos} < level);
    end

endmodule

// File: rtl/led_ind_ustate_enc.sv
// Link power state indicator encoder.
// Registers the two-pin encoding of the link power state. Both pins are
// released (enables low, values low) when low-power states are disabled.
// Assumes: ustate and lpm_en are synchronous to clk.
module led_ind_ustate_enc
    import led_ind_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] ustate,
    input  logic       lpm_en,
    output logic [1:0] pins,
    output logic       pins_oe
);
    logic [1:0] pins_q;
    logic       oe_q;

    // Output stage: encodes the state when enabled, otherwise releases the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q <= 2'b00;
            oe_q   <= 1'b0;
        end else begin
            pins_q <= lpm_en ? ustate_pins(ustate) : 2'b00;
            oe_q   <= lpm_en;
        end
    end

    assign pins    = pins_q;
    assign pins_oe = oe_q;

    AST_U3_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (lpm_en && ustate == 3'd3) |=> (pins_q == 2'b11 && oe_q)); // R7

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !lpm_en |=> (!oe_q && pins_q == 2'b00)); // R8

endmodule

// File: rtl/usb_link_led_ctrl.sv
// USB link status LED indicator controller (top).
// Combines the shared PWM timebase, the main-LED pattern generator, the
// heartbeat generator, one active-low comparator per LED channel and the
// power-state indicator encoder.
// Assumes: CLK_HZ >= PWM_HZ * 2^DUTY_W; all inputs synchronous to clk.
module usb_link_led_ctrl #(
    parameter int CLK_HZ          = 40_000_000,
    parameter int PWM_HZ          = 1000,
    parameter int DUTY_W          = 8,
    parameter int BLINK_HALF_USB2 = 100,
    parameter int BLINK_HALF_SS   = 50,
    parameter int FADE_HOLD       = 4,
    parameter int BEAT_HALF       = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       link_up,
    input  logic       link_ss,
    input  logic       disk_busy,
    input  logic       link_susp,
    input  logic [2:0] ustate,
    input  logic       lpm_en,
    output logic       led_main_n,
    output logic       led_beat_n,
    output logic       ind_a,
    output logic       ind_b,
    output logic       ind_a_oe,
    output logic       ind_b_oe
);
    localparam int RAW_DIV  = CLK_HZ / (PWM_HZ * (1 << DUTY_W));
    localparam int STEP_DIV = (RAW_DIV < 1) ? 1 : RAW_DIV;
    localparam int NUM_CH   = 2;

    logic [DUTY_W-1:0] pwm_pos;
    logic              period_end;
    logic [DUTY_W:0]   ch_level [NUM_CH];
    logic [NUM_CH-1:0] ch_led_n;
    logic [1:0]        pins;
    logic              pins_oe;

    led_ind_timebase #(.STEP_DIV(STEP_DIV), .DUTY_W(DUTY_W)) i_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwm_pos    (pwm_pos),
        .period_end (period_end)
    );

    led_ind_main_pattern #(
        .DUTY_W          (DUTY_W),
        .BLINK_HALF_USB2 (BLINK_HALF_USB2),
        .BLINK_HALF_SS   (BLINK_HALF_SS),
        .FADE_HOLD       (FADE_HOLD)
    ) i_main_pattern (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_end (period_end),
        .link_up    (link_up),
        .link_ss    (link_ss),
        .disk_busy  (disk_busy),
        .link_susp  (link_susp),
        .level      (ch_level[0])
    );

    led_ind_beat #(.DUTY_W(DUTY_W), .BEAT_HALF(BEAT_HALF)) i_beat (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_end (period_end),
        .level      (ch_level[1])
    );

    // One comparator per LED channel, all sharing the PWM position.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        led_ind_pwm_out #(.DUTY_W(DUTY_W)) i_pwm_out (
            .pwm_pos (pwm_pos),
            .level   (ch_level[g]),
            .led_n   (ch_led_n[g])
        );
    end

    led_ind_ustate_enc i_ustate_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .ustate  (ustate),
        .lpm_en  (lpm_en),
        .pins    (pins),
        .pins_oe (pins_oe)
    );

    assign led_main_n = ch_led_n[0];
    assign led_beat_n = ch_led_n[1];
    assign ind_a      = pins[0];
    assign ind_b      = pins[1];
    assign ind_a_oe   = pins_oe;
    assign ind_b_oe   = pins_oe;

    AST_OFFLINE_DARK_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(period_end) && !$past(link_up)) |-> led_main_n); // R1

endmodule

// File: tb/test_usb_link_led_ctrl.sv
// Bench for usb_link_led_ctrl in a small configuration: 3-bit duty,
// 2 clocks per step (16-clock PWM period), short blink/fade/beat windows.
module test_usb_link_led_ctrl;
    localparam int W    = 3;
    localparam int SD   = 2;
    localparam int P    = SD * (1 << W);
    localparam int HS   = 6;
    localparam int SS   = 3;
    localparam int FH   = 2;
    localparam int BH   = 5;
    localparam int HMAX = 16384;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_up = 1'b0, link_ss = 1'b0, disk_busy = 1'b0, link_susp = 1'b0;
    logic [2:0] ustate = 3'd0;
    logic       lpm_en = 1'b0;
    logic       led_main_n, led_beat_n, ind_a, ind_b, ind_a_oe, ind_b_oe;

    int  total = 0;
    int  bad = 0;
    bit  finished = 0;
    longint m = 0;
    int  nwin = 0;
    int  lows_m = 0, lows_b = 0;
    bit  hi_m = 0, hi_b = 0;
    int  prefix_err = 0;
    int  hist_m [HMAX];
    int  hist_b [HMAX];

    usb_link_led_ctrl #(
        .CLK_HZ(16), .PWM_HZ(1), .DUTY_W(W),
        .BLINK_HALF_USB2(HS), .BLINK_HALF_SS(SS),
        .FADE_HOLD(FH), .BEAT_HALF(BH)
    ) i_usb_link_led_ctrl (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .link_ss(link_ss),
        .disk_busy(disk_busy), .link_susp(link_susp), .ustate(ustate),
        .lpm_en(lpm_en), .led_main_n(led_main_n), .led_beat_n(led_beat_n),
        .ind_a(ind_a), .ind_b(ind_b), .ind_a_oe(ind_a_oe), .ind_b_oe(ind_b_oe)
    );

    always #2.5 clk = ~clk;

    // Counts clock edges since reset release; m mod P is the period position.
    always @(posedge clk) begin
        if (!rst_n) m <= 0;
        else        m <= m + 1;
    end

    // Per-period measurement of low cycles and of a single leading low run.
    always @(negedge clk) begin
        if (!rst_n) begin
            lows_m = 0; lows_b = 0; hi_m = 0; hi_b = 0; nwin = 0;
        end else begin
            if (led_main_n == 1'b0) begin lows_m++; if (hi_m) prefix_err++; end
            else hi_m = 1;
            if (led_beat_n == 1'b0) begin lows_b++; if (hi_b) prefix_err++; end
            else hi_b = 1;
            if ((m % P) == P - 1) begin
                if (nwin < HMAX) begin hist_m[nwin] = lows_m; hist_b[nwin] = lows_b; end
                nwin++;
                lows_m = 0; lows_b = 0; hi_m = 0; hi_b = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_win(input int k);
        int t;
        t = nwin + k;
        while (nwin < t) @(negedge clk);
    endtask

    task automatic drive(input bit up, input bit ss, input bit busy, input bit susp);
        @(posedge clk); #1;
        link_up = up; link_ss = ss; disk_busy = busy; link_susp = susp;
    endtask

    function automatic int hv(input bit beat, input int i);
        return beat ? hist_b[i] : hist_m[i];
    endfunction

    // Every period in the range must have the given low count.
    task automatic check_const(input int s, input int n, input int exp, input string tag);
        int wrong;
        int act;
        wrong = 0; act = exp;
        for (int i = s; i < s + n; i++)
            if (hist_m[i] != exp) begin wrong++; act = hist_m[i]; end
        chk(wrong == 0, tag, act, exp);
    endtask

    // Alternating full/dark runs: interior runs must be exactly `half` periods.
    task automatic check_runs(input bit beat, input int s, input int e, input int half,
                              input string tag);
        int i;
        int r;
        int v;
        int prev;
        int nruns;
        i = s;
        while (i < e && hv(beat, i) == hv(beat, s)) i++;
        prev = hv(beat, s);
        nruns = 0;
        while (i < e) begin
            r = i; v = hv(beat, i);
            while (i < e && hv(beat, i) == v) i++;
            if (i >= e) break;
            chk((v == P || v == 0) && v != prev, tag, v, (prev == 0) ? P : 0);
            chk(i - r == half, tag, i - r, half);
            prev = v;
            nruns++;
        end
        chk(nruns >= 2, tag, nruns, 2);
    endtask

    // Fade staircase: interior runs of FH periods, steps of one level, full range.
    task automatic check_fade(input int s, input int e, input string tag);
        int i;
        int r;
        int v;
        int prev;
        int nruns;
        int lo;
        int hi;
        int diff;
        i = s;
        while (i < e && hist_m[i] == hist_m[s]) i++;
        prev = -1; nruns = 0; lo = P; hi = 0;
        while (i < e) begin
            r = i; v = hist_m[i];
            while (i < e && hist_m[i] == v) i++;
            if (i >= e) break;
            chk(v % SD == 0, {tag, " R5 quantum"}, v % SD, 0);
            chk(i - r == FH, tag, i - r, FH);
            if (prev >= 0) begin
                diff = (v > prev) ? v - prev : prev - v;
                chk(diff == SD, tag, diff, SD);
            end
            if (v < lo) lo = v;
            if (v > hi) hi = v;
            prev = v;
            nruns++;
        end
        chk(lo == 0, {tag, " floor"}, lo, 0);
        chk(hi == P, {tag, " ceiling"}, hi, P);
        chk(nruns >= 2 * (1 << W), {tag, " runs"}, nruns, 2 * (1 << W));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int s;
        bit ea;
        bit eb;
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R10: reset state at the ports
        chk(led_main_n == 1'b1, "R10 main dark in reset", led_main_n, 1);
        chk(led_beat_n == 1'b0, "R10 beat lit in reset", led_beat_n, 0);
        chk(ind_a_oe == 1'b0 && ind_b_oe == 1'b0, "R10 pins released", ind_a_oe, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R1: disconnected keeps the main LED dark
        wait_win(2); s = nwin; wait_win(20);
        check_const(s, 20, 0, "R1 disconnected");
        chk(hist_b[0] == P, "R6 beat starts on", hist_b[0], P);

        // R2: connected idle is steady on
        drive(1, 0, 0, 0);
        wait_win(2); s = nwin; wait_win(10);
        check_const(s, 10, P, "R2 steady on");

        // R3: activity blink on a USB2 link
        drive(1, 0, 1, 0);
        wait_win(1); s = nwin; wait_win(40);
        check_runs(0, s, nwin, HS, "R3 blink usb2");

        // R3: activity blink on a SuperSpeed link
        drive(1, 1, 1, 0);
        wait_win(2); s = nwin; wait_win(30);
        check_runs(0, s, nwin, SS, "R3 blink ss");

        // R4: suspend fade takes precedence over activity
        drive(1, 1, 1, 1);
        wait_win(1); s = nwin; wait_win(80);
        check_fade(s, nwin, "R4 fade");

        // R1: disconnection overrides fade and blink
        drive(0, 1, 1, 1);
        wait_win(2); s = nwin; wait_win(10);
        check_const(s, 10, 0, "R1 priority");

        // R9/R5: each period carries one leading low run
        chk(prefix_err == 0, "R9 single low run per period", prefix_err, 0);

        // R6: heartbeat unaffected by all link traffic above
        check_runs(1, 0, nwin, BH, "R6 heartbeat");

        // R7/R8: indicator pin sweep
        for (int en = 0; en < 2; en++) begin
            for (int u = 0; u < 8; u++) begin
                @(posedge clk); #1;
                lpm_en = en[0]; ustate = u[2:0];
                @(posedge clk); @(negedge clk);
                ea = en[0] && (u == 1 || u == 3);
                eb = en[0] && (u == 2 || u == 3);
                if (en == 1) begin
                    chk(ind_a == ea, "R7 pin a", ind_a, ea);
                    chk(ind_b == eb, "R7 pin b", ind_b, eb);
                    chk(ind_a_oe && ind_b_oe, "R7 enables", ind_a_oe, 1);
                end else begin
                    chk(!ind_a && !ind_b, "R8 pin values", {ind_b, ind_a}, 0);
                    chk(!ind_a_oe && !ind_b_oe, "R8 enables", {ind_b_oe, ind_a_oe}, 0);
                end
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule